// File: doc/BRIEF.md
# SPI Master Port with Transmit and Receive Queues

This block is a serial port that acts as the clock-driving end of an SPI link. Software configures it through six word-indexed registers. Frames written to the data register go into an eight-entry transmit queue. A shifter sends each frame on the MOSI pin, most significant bit first, and samples MISO in the same frame. Each received frame goes into an eight-entry receive queue, and a read of the data register takes it out.

The frame length can be set from 4 to 16 bits. The idle level of the clock and the sampling edge can each be selected, which gives all four clock modes. The bit clock comes from a two-stage divider: an even prescale value multiplied by one plus a rate value. One interrupt line combines three enabled sources: the receive queue is at least half full, the transmit queue is at most half full, or a receive overrun has been latched. A loopback mode routes the port's own MOSI back into the receiver, so it can be tested without a slave.

Top module: `spim_top`

## Requirements
- R1: After reset, register 3 (status) reads 0x0003, registers 1 and 5 read 0, SCLK is low and irq is low.
- R2: The word index selects the register: 0 config A, 1 config B, 2 data, 3 status, 4 prescale, 5 interrupt status. Config A keeps bits 15:8 (rate), bit 7 (phase), bit 6 (polarity) and bits 3:0 (frame size minus one), and bits 5:4 read as zero. Config B keeps bits 6:0. Prescale keeps bits 7:0.
- R3: The frame length N is config A bits 3:0 plus one, and values below 3 act as N=4. The low N bits of a written word are sent MSB first. A received frame reads back right-justified, with the bits above N at zero.
- R4: SCLK idles at the polarity bit. With the phase bit at 0, data is sampled on the first (leading) edge of each bit. With the phase bit at 1, it is sampled on the second (trailing) edge. A frame has exactly 2N SCLK edges.
- R5: Each SCLK half period lasts (prescale[7:1])*(1+rate) clock cycles. Prescale bit 0 is ignored, and a value of prescale[7:1] equal to 0 acts as 1.
- R6: Frames shift only while config B bit 4 is set. While it is clear, SCLK holds its idle level and queued data stays queued.
- R7: When config B bit 3 is set, the receiver takes its data from the port's own MOSI. When it is clear, the receiver takes its data from the spi_miso pin.
- R8: Each queue holds 8 frames. A data write when the transmit queue is full is dropped. A data read when the receive queue is empty returns 0 and removes nothing.
- R9: Status bits: bit 0 transmit queue empty, bit 1 transmit queue not full, bit 2 receive queue not empty, bit 3 receive queue full, bit 4 busy (transmit queue not empty or a frame in progress). All other bits are zero.
- R10: If a frame completes while the receive queue is full, that frame is discarded and the overrun flag is set. The flag stays set until any write to register 5.
- R11: Interrupt status bit 0 = (receive count >= 4) AND config B bit 0. Bit 1 = (transmit count <= 4) AND config B bit 1. Bit 2 = overrun flag AND config B bit 2. irq is the OR of these three bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the source of the bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_sel | input | 1 | Register access strobe, one cycle per access |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_idx | input | 3 | Word index of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the same cycle as the strobe |
| spi_sclk | output | 1 | Serial bit clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| irq | output | 1 | Combined interrupt request |

## Verification
The checker assumes that the register port sees at most one access per cycle. It also assumes that reg_sel is held for exactly one cycle, so one data read removes exactly one frame. The bench accesses registers only through tasks that hold the strobe for a single cycle between falling edges. The bench changes the clock mode, frame size and divider only while the port is disabled. So a mid-frame reconfiguration, which the properties do not model, never occurs. spi_miso is held constant during each frame.

// File: rtl/spim_pkg.sv
// Package for the SPI master: register word indices and the positions of the
// config B control bits. The top module and the bench both import it.
package spim_pkg;
    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        REG_CFGA  = 3'd0,
        REG_CFGB  = 3'd1,
        REG_DATA  = 3'd2,
        REG_STAT  = 3'd3,
        REG_PRESC = 3'd4,
        REG_INT   = 3'd5
    } reg_idx_e;

    localparam int CB_RXIE = 0;
    localparam int CB_TXIE = 1;
    localparam int CB_OVIE = 2;
    localparam int CB_LOOP = 3;
    localparam int CB_EN   = 4;
endpackage

// File: rtl/spim_fifo.sv
// Synchronous queue used for both directions of the port.
// Assumes DEPTH is a power of two. A push when the queue is full and a pop
// when it is empty are ignored. head shows the oldest entry.
module spim_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         empty,
    output logic                         full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Storage write for accepted pushes.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/spim_baud.sv
// Two-stage bit-clock divider. While run is high it emits a one-cycle tick
// once every (presc[7:1])*(1+rate) cycles; each tick marks one SCLK half
// period. Prescale bit 0 is ignored, and a halved prescale of 0 acts as 1.
// Both counters are held at zero while run is low, so the first tick comes
// one full half period after run rises.
module spim_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] presc,
    input  logic [DIV_W-1:0] rate,
    output logic             tick
);
    localparam int PRE_W = DIV_W - 1;

    logic [PRE_W-1:0] half_pre, pre_cnt;
    logic [DIV_W-1:0] rate_cnt;
    logic             pre_wrap;

    assign half_pre = (presc[DIV_W-1:1] == '0) ? PRE_W'(1) : presc[DIV_W-1:1];
    assign pre_wrap = (pre_cnt == half_pre - 1'b1);
    assign tick     = run && pre_wrap && (rate_cnt == rate);

    // Prescale counter, followed by the rate counter it advances.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_cnt  <= '0;
            rate_cnt <= '0;
        end else if (pre_wrap) begin
            pre_cnt  <= '0;
            rate_cnt <= (rate_cnt == rate) ? '0 : rate_cnt + 1'b1;
        end else begin
            pre_cnt  <= pre_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spim_shift.sv
// Frame shifter. When the port is enabled and idle with a frame waiting, it
// pops the frame and runs 2N half periods, toggling SCLK on each tick.
// Sampling happens on ticks whose index parity equals the phase bit; the
// outgoing data moves on the other ticks, except the first. The received
// word is handed over one cycle after the last tick. Clearing the enable
// aborts a frame, and that frame is not delivered.
module spim_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         cpol,
    input  logic         cpha,
    input  logic [3:0]   size_m1,
    input  logic         loop,
    input  logic         tick,
    input  logic         tx_avail,
    input  logic [W-1:0] tx_word,
    input  logic         miso,
    output logic         tx_pop,
    output logic         rx_push,
    output logic [W-1:0] rx_word,
    output logic         active,
    output logic         busy,
    output logic         sclk,
    output logic         mosi
);
    localparam int SH_W = $clog2(W + 1);
    localparam int K_W  = $clog2(2 * W);

    logic [SH_W-1:0] nbits;
    logic [K_W-1:0]  k, last_k;
    logic [W-1:0]    shreg, rxsh;
    logic            din, start, sample_now;

    assign nbits      = (size_m1 < 4'd3) ? SH_W'(4) : SH_W'(size_m1) + 1'b1;
    assign last_k     = K_W'({1'b0, nbits, 1'b0} - 7'd1);
    assign start      = en && !active && tx_avail;
    assign tx_pop     = start;
    assign mosi       = shreg[W-1];
    assign din        = loop ? mosi : miso;
    assign sample_now = (k[0] == cpha);
    assign rx_word    = rxsh;
    assign busy       = active || rx_push;

    // Frame sequencing: the clock level, the tick index and both shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            sclk   <= 1'b0;
            shreg  <= '0;
            rxsh   <= '0;
            k      <= '0;
        end else if (!en) begin
            active <= 1'b0;
            sclk   <= cpol;
        end else if (start) begin
            active <= 1'b1;
            sclk   <= cpol;
            shreg  <= tx_word << (SH_W'(W) - nbits);
            rxsh   <= '0;
            k      <= '0;
        end else if (active) begin
            if (tick) begin
                sclk <= ~sclk;
                if (sample_now)      rxsh  <= {rxsh[W-2:0], din};
                else if (k != '0)    shreg <= shreg << 1;
                if (k == last_k) active <= 1'b0;
                else             k      <= k + 1'b1;
            end
        end else begin
            sclk <= cpol;
        end
    end

    // One-cycle delivery strobe issued after the last tick of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_push <= 1'b0;
        else        rx_push <= en && active && tick && (k == last_k);
    end
endmodule

// File: rtl/spim_top.sv
// SPI master port with register access. It holds the config, prescale and
// overrun state, decodes the register port, and connects the two queues,
// the divider and the shifter. Assumes one register access per cycle; a
// read of the data register removes one frame from the receive queue.
module spim_top
    import spim_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 8,
    parameter int DIV_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_idx,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              irq
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam int HALF  = FIFO_DEPTH / 2;

    logic [3:0]        size_m1;
    logic              mode_pol, mode_pha;
    logic [DIV_W-1:0]  rate, presc;
    logic [6:0]        cfgb;
    logic              ovr_flag;

    logic              wr_hit, rd_hit, ovr_clr, port_en;
    logic              tx_pop, tx_empty, tx_full;
    logic              rx_push, rx_pop, rx_empty, rx_full;
    logic [CNT_W-1:0]  tx_cnt, rx_cnt;
    logic [DATA_W-1:0] tx_head, rx_head, rx_word;
    logic              tick, shift_active, shift_busy;
    logic [2:0]        int_vec;

    assign wr_hit  = reg_sel && reg_wr;
    assign rd_hit  = reg_sel && !reg_wr;
    assign ovr_clr = wr_hit && (reg_idx == REG_INT);
    assign rx_pop  = rd_hit && (reg_idx == REG_DATA);
    assign port_en = cfgb[CB_EN];

    // Configuration registers written from the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_m1  <= '0;
            mode_pol <= 1'b0;
            mode_pha <= 1'b0;
            rate     <= '0;
            cfgb     <= '0;
            presc    <= '0;
        end else if (wr_hit) begin
            case (reg_idx)
                REG_CFGA: begin
                    rate     <= reg_wdata[15:8];
                    mode_pha <= reg_wdata[7];
                    mode_pol <= reg_wdata[6];
                    size_m1  <= reg_wdata[3:0];
                end
                REG_CFGB:  cfgb  <= reg_wdata[6:0];
                REG_PRESC: presc <= reg_wdata[7:0];
                default: ;
            endcase
        end
    end

    // Sticky overrun flag: a completed frame that finds the receive queue
    // full sets it; any write to the interrupt register clears it. A set in
    // the same cycle as a clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ovr_flag <= 1'b0;
        else if (rx_push && rx_full) ovr_flag <= 1'b1;
        else if (ovr_clr)           ovr_flag <= 1'b0;
    end

    spim_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(wr_hit && (reg_idx == REG_DATA)), .push_data(reg_wdata[DATA_W-1:0]),
        .pop(tx_pop), .head(tx_head), .count(tx_cnt),
        .empty(tx_empty), .full(tx_full)
    );

    spim_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_word),
        .pop(rx_pop), .head(rx_head), .count(rx_cnt),
        .empty(rx_empty), .full(rx_full)
    );

    spim_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(shift_active),
        .presc(presc), .rate(rate), .tick(tick)
    );

    spim_shift #(.W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .en(port_en),
        .cpol(mode_pol), .cpha(mode_pha), .size_m1(size_m1),
        .loop(cfgb[CB_LOOP]), .tick(tick),
        .tx_avail(!tx_empty), .tx_word(tx_head), .miso(spi_miso),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
        .active(shift_active), .busy(shift_busy),
        .sclk(spi_sclk), .mosi(spi_mosi)
    );

    // Interrupt sources, each gated by its enable bit in config B.
    always_comb begin
        int_vec[0] = (rx_cnt >= CNT_W'(HALF)) && cfgb[CB_RXIE];
        int_vec[1] = (tx_cnt <= CNT_W'(HALF)) && cfgb[CB_TXIE];
        int_vec[2] = ovr_flag && cfgb[CB_OVIE];
    end
    assign irq = |int_vec;

    // Read-data multiplexer; returns zero when no read is in progress.
    always_comb begin
        reg_rdata = '0;
        if (rd_hit) begin
            case (reg_idx)
                REG_CFGA:  reg_rdata = {rate, mode_pha, mode_pol, 2'b00, size_m1};
                REG_CFGB:  reg_rdata = {9'd0, cfgb};
                REG_DATA:  reg_rdata = rx_empty ? '0 : 16'(rx_head);
                REG_STAT:  reg_rdata = {11'd0, shift_busy || !tx_empty, rx_full,
                                        !rx_empty, !tx_full, tx_empty};
                REG_PRESC: reg_rdata = {8'd0, presc};
                REG_INT:   reg_rdata = {13'd0, int_vec};
                default:   reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/spim_chk.sv
// Checker for spim_top, attached with bind. It watches the queue counts,
// the overrun flag and the link between the enable, the shifter activity
// and the SCLK idle level. Assumes one register access per cycle.
module spim_chk #(
    parameter int CNT_W = 4,
    parameter int DEPTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] tx_cnt,
    input logic [CNT_W-1:0] rx_cnt,
    input logic             rx_push,
    input logic             rx_pop,
    input logic             rx_full,
    input logic             ovr_flag,
    input logic             ovr_clr,
    input logic             port_en,
    input logic             shift_active,
    input logic             sclk,
    input logic             cpol
);
    // R8
    tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= CNT_W'(DEPTH));
    // R8
    rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CNT_W'(DEPTH));
    // R10
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push && rx_full |=> ovr_flag);
    // R10
    ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag && !ovr_clr |=> ovr_flag);
    // R10
    ovr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push && rx_full && !rx_pop |=> rx_cnt == CNT_W'(DEPTH));
    // R6
    halt_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> !shift_active);
    // R4
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_active |=> sclk == $past(cpol));
endmodule

bind spim_top spim_chk #(.CNT_W(CNT_W), .DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .rx_push(rx_push), .rx_pop(rx_pop), .rx_full(rx_full),
    .ovr_flag(ovr_flag), .ovr_clr(ovr_clr), .port_en(port_en),
    .shift_active(shift_active), .sclk(spi_sclk), .cpol(mode_pol)
);

// File: tb/tb_spim_top.sv
module tb_spim_top;
    import spim_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_wr = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        spi_sclk, spi_mosi, irq;
    logic        spi_miso = 1'b0;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // Pin monitor: the clock mode in use, captured MOSI bits, edge count and times.
    logic        mon_pol = 1'b0, mon_pha = 1'b0;
    logic [15:0] mon_cap = '0;
    int          mon_edges = 0;
    time         t_last = 0, t_prev = 0;

    always #4 clk = ~clk;

    spim_top dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .irq(irq)
    );

    always @(spi_sclk) begin
        if (rst_n) begin
            mon_edges = mon_edges + 1;
            t_prev = t_last;
            t_last = $time;
            if ((spi_sclk != mon_pol) ^ mon_pha) mon_cap = {mon_cap[14:0], spi_mosi};
        end
    end

    // Vectors: {config A, prescale, transmit word}; all run in loopback.
    localparam logic [39:0] VEC [6] = '{
        {16'h0007, 8'd2, 16'hA5C3},
        {16'h014F, 8'd4, 16'h8001},
        {16'h0083, 8'd6, 16'h00F9},
        {16'h02CB, 8'd2, 16'h5A3C},
        {16'h0045, 8'd0, 16'hFFEA},
        {16'h008E, 8'd3, 16'h7FFE}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_idx = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_idx = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_sel = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 4000; i++) begin
            rd(REG_STAT, s);
            if (!s[4]) break;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(REG_STAT, v);  check("R1 status", v, 16'h0003);
        rd(REG_CFGB, v);  check("R1 cfgB", v, 0);
        rd(REG_INT, v);   check("R1 int", v, 0);
        check("R1 sclk/irq", {spi_sclk, irq}, 0);

        // R2 readback of the fields that are kept
        wr(REG_CFGA, 16'hABF7); rd(REG_CFGA, v); check("R2 cfgA", v, 16'hABC7);
        wr(REG_CFGB, 16'hFF67); rd(REG_CFGB, v); check("R2 cfgB", v, 16'h0067);
        wr(REG_PRESC, 16'h1235); rd(REG_PRESC, v); check("R2 presc", v, 16'h0035);
        wr(REG_CFGB, 16'h0000);

        // Vector walk: R3 size/order, R4 mode/edges, R5 timing, R7 loopback
        for (int i = 0; i < 6; i++) begin
            logic [15:0] c0, tx, exp;
            logic [7:0]  ps;
            int n, hp, e0;
            {c0, ps, tx} = VEC[i];
            n   = (c0[3:0] < 3) ? 4 : c0[3:0] + 1;
            exp = tx & 16'((32'd1 << n) - 1);
            hp  = (ps[7:1] == 0) ? 1 : ps[7:1];
            wr(REG_CFGB, 0);
            wr(REG_CFGA, c0);
            wr(REG_PRESC, {8'd0, ps});
            mon_pol = c0[6]; mon_pha = c0[7];
            wr(REG_CFGB, 16'h0018);
            repeat (3) @(negedge clk);
            e0 = mon_edges;
            wr(REG_DATA, tx);
            wait_idle();
            check("R4 edge count", mon_edges - e0, 2 * n);
            check("R3 mosi order", mon_cap & exp | (mon_cap & ~16'((32'd1 << n) - 1) & 16'h0), exp);
            check("R4 idle level", spi_sclk, c0[6]);
            check("R5 half period", 32'(t_last - t_prev), hp * (c0[15:8] + 1) * 8);
            rd(REG_DATA, v); check("R3 R7 loopback data", v, exp);
        end

        // R6 disabled port holds the frame
        wr(REG_CFGB, 0); wr(REG_CFGA, 16'h0007); wr(REG_PRESC, 16'd2);
        mon_pol = 1'b0; mon_pha = 1'b0;
        repeat (3) @(negedge clk);
        begin
            int e0;
            e0 = mon_edges;
            wr(REG_DATA, 16'h0011);
            repeat (60) @(negedge clk);
            check("R6 no edges while off", mon_edges - e0, 0);
            rd(REG_STAT, v); check("R6 R9 status while off", v, 16'h0012);
        end
        wr(REG_CFGB, 16'h0018); wait_idle();
        rd(REG_DATA, v); check("R6 frame after enable", v, 16'h0011);

        // R7 receiver on the miso pin
        wr(REG_CFGB, 16'h0010);
        spi_miso = 1'b1; wr(REG_DATA, 16'h0000); wait_idle();
        rd(REG_DATA, v); check("R7 miso high", v, 16'h00FF);
        spi_miso = 1'b0; wr(REG_DATA, 16'h00FF); wait_idle();
        rd(REG_DATA, v); check("R7 miso low", v, 16'h0000);

        // R8 empty read
        rd(REG_DATA, v); check("R8 empty read", v, 0);
        rd(REG_STAT, v); check("R8 R9 status idle", v, 16'h0003);

        // R8 full transmit queue drops the ninth word
        wr(REG_CFGB, 0);
        for (int i = 1; i <= 9; i++) wr(REG_DATA, 16'(i));
        rd(REG_STAT, v); check("R9 tx full status", v, 16'h0010);
        wr(REG_CFGB, 16'h0018); wait_idle();
        rd(REG_STAT, v); check("R9 rx full status", v, 16'h000F);
        begin
            logic ok = 1'b1;
            for (int i = 1; i <= 8; i++) begin
                rd(REG_DATA, v);
                if (v !== 16'(i)) ok = 1'b0;
            end
            check("R8 first eight kept", ok, 1);
        end
        rd(REG_STAT, v); check("R8 ninth dropped", v, 16'h0003);

        // R11 level interrupts
        wr(REG_CFGB, 16'h0002);
        rd(REG_INT, v); check("R11 tx level empty", {v, irq}, {16'h0002, 1'b1});
        for (int i = 0; i < 4; i++) wr(REG_DATA, 16'h21 + 16'(i));
        rd(REG_INT, v); check("R11 tx level four", v, 16'h0002);
        wr(REG_DATA, 16'h25);
        rd(REG_INT, v); check("R11 tx level five", {v, irq}, {16'h0000, 1'b0});
        wr(REG_CFGB, 16'h001B); wait_idle();
        rd(REG_INT, v); check("R11 rx level five", v, 16'h0003);
        rd(REG_DATA, v); rd(REG_DATA, v);
        rd(REG_INT, v); check("R11 rx level three", v, 16'h0002);
        for (int i = 0; i < 3; i++) rd(REG_DATA, v);

        // R10 overrun
        wr(REG_CFGB, 0); wr(REG_CFGB, 16'h001C);
        for (int i = 0; i < 8; i++) wr(REG_DATA, 16'h31 + 16'(i));
        wait_idle();
        rd(REG_INT, v); check("R10 no overrun at full", v, 0);
        wr(REG_DATA, 16'h39); wait_idle();
        rd(REG_INT, v); check("R10 overrun flag", {v, irq}, {16'h0004, 1'b1});
        begin
            logic ok = 1'b1;
            for (int i = 0; i < 8; i++) begin
                rd(REG_DATA, v);
                if (v !== 16'h31 + 16'(i)) ok = 1'b0;
            end
            check("R10 overrun frame discarded", ok, 1);
        end
        rd(REG_INT, v); check("R10 flag sticky", v, 16'h0004);
        wr(REG_INT, 0);
        rd(REG_INT, v); check("R10 flag cleared", {v, irq}, {16'h0000, 1'b0});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule